// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the central sequencer of a multicycle processor in which a single memory serves both instruction fetch and data access. Each instruction walks through several short states; in every state the block drives the select, enable and write strobes that steer the shared memory, the register file, the ALU and the program counter. The datapath registers are outside the block. The instruction register, MDR, A, B and ALUOut all keep their usual roles there, and the memory data register loads on every cycle.

The instructions handled are register-register ALU operations, word load, word store, branch-if-equal, and a jump through memory. The jump through memory reads the new program counter from the word addressed by register rt. It also stores the return address (the already incremented PC) at rs plus the sign-extended offset. The datapath can read the target word while the ALU forms the store address, and it can write the return address in the next cycle while the PC takes the word just read. The whole jump therefore takes four cycles including fetch and decode.

Decoding happens in exactly one state. Every later state reaches its successor without looking at the opcode input again. The state register resets synchronously to the fetch state.

Top module: `mc_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is fetch. This holds even in the middle of an instruction.
- R2: Fetch drives addr_sel=0 (PC), mem_rd=1, ir_wr=1, alu_src_a=0, alu_src_b=1 (constant 4), alu_op=0 (add), pc_src=0 (ALU result), pc_wr=1. Fetch is always followed by decode.
- R3: Decode drives alu_src_a=0, alu_src_b=3 (shifted offset), alu_op=0. It then branches on `opcode`: 0 for register ops, 35 for load, 43 for store, 4 for branch, and parameter OP_JMEM (60 by default) for the jump.
- R4: A register op spends one execute cycle (alu_src_a=1, alu_src_b=0, alu_op=2 meaning func field) and then one writeback cycle (reg_dst=1, reg_wr=1) before fetch.
- R5: A load runs an address cycle (alu_src_a=1, alu_src_b=2 sign-extended offset, alu_op=0), then a read cycle (addr_sel=1 ALUOut, mem_rd=1), then a writeback cycle (mem_to_reg=1, reg_wr=1, reg_dst=0) before fetch.
- R6: A store runs the same address cycle as a load, then a write cycle (addr_sel=1, mem_wr=1, wdata_sel=0 register B) before fetch.
- R7: A branch spends one cycle with alu_src_a=1, alu_src_b=0, alu_op=1 (subtract) and pc_src=1 (ALUOut). In that cycle pc_wr equals `zero`.
- R8: The jump has two cycles. The first is addr_sel=2 (register B), mem_rd=1, alu_src_a=1, alu_src_b=2, alu_op=0. The second is addr_sel=1, mem_wr=1, wdata_sel=1 (PC), pc_src=2 (memory data register), pc_wr=1. Fetch follows.
- R9: An opcode that none of the supported instructions use returns the sequencer from decode straight to fetch.
- R10: Every output not named for a state is 0. mem_rd and mem_wr are never high together.
- R11: `opcode` has no effect outside decode, and `zero` has no effect outside the branch cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | OPW | Opcode field from the instruction register |
| zero | input | 1 | ALU zero flag |
| addr_sel | output | 2 | Memory address select: 0 PC, 1 ALUOut, 2 register B |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_wr | output | 1 | Instruction register load |
| reg_dst | output | 1 | Destination register: 0 rt, 1 rd |
| mem_to_reg | output | 1 | Register write data: 0 ALUOut, 1 memory data register |
| reg_wr | output | 1 | Register file write enable |
| alu_src_a | output | 1 | ALU A input: 0 PC, 1 register A |
| alu_src_b | output | 2 | ALU B input: 0 register B, 1 constant 4, 2 offset, 3 offset shifted by two |
| alu_op | output | 2 | ALU control: 0 add, 1 subtract, 2 func field |
| pc_src | output | 2 | PC source: 0 ALU result, 1 ALUOut, 2 memory data register |
| pc_wr | output | 1 | PC write enable |
| wdata_sel | output | 1 | Memory write data: 0 register B, 1 PC |

## Verification
The bench builds the sequencer with its default parameters: a 6-bit opcode and 60 as the jump opcode. Because the jump code sits well away from the four standard codes, the bench can also try an unused code such as 2. In the cycles where the opcode must be ignored, the bench drives codes that are valid, among them the load, store and jump codes. A leak of the opcode into any state other than decode would then show as a different next state. The `zero` flag toggles in every cycle outside the branch cycle, and the branch runs once with the flag set and once with it clear.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

  typedef enum logic [3:0] {
    S_FETCH  = 4'd0,
    S_DECODE = 4'd1,
    S_LWADR  = 4'd2,
    S_LWRD   = 4'd3,
    S_LWWB   = 4'd4,
    S_SWADR  = 4'd5,
    S_SWWR   = 4'd6,
    S_REXE   = 4'd7,
    S_RWB    = 4'd8,
    S_BEQ    = 4'd9,
    S_JMADR  = 4'd10,
    S_JMST   = 4'd11
  } state_t;

  localparam int SELW = 2;

  localparam logic [SELW-1:0] ALU_ADD  = 2'd0;
  localparam logic [SELW-1:0] ALU_SUB  = 2'd1;
  localparam logic [SELW-1:0] ALU_FUNC = 2'd2;

  localparam logic [SELW-1:0] AS_PC     = 2'd0;
  localparam logic [SELW-1:0] AS_ALUOUT = 2'd1;
  localparam logic [SELW-1:0] AS_REGB   = 2'd2;

  localparam logic [SELW-1:0] SB_REGB  = 2'd0;
  localparam logic [SELW-1:0] SB_FOUR  = 2'd1;
  localparam logic [SELW-1:0] SB_IMM   = 2'd2;
  localparam logic [SELW-1:0] SB_IMMSH = 2'd3;

  localparam logic [SELW-1:0] PS_ALU    = 2'd0;
  localparam logic [SELW-1:0] PS_ALUOUT = 2'd1;
  localparam logic [SELW-1:0] PS_MDR    = 2'd2;

  typedef struct packed {
    logic [SELW-1:0] addr_sel;
    logic            mem_rd;
    logic            mem_wr;
    logic            ir_wr;
    logic            reg_dst;
    logic            mem_to_reg;
    logic            reg_wr;
    logic            alu_src_a;
    logic [SELW-1:0] alu_src_b;
    logic [SELW-1:0] alu_op;
    logic [SELW-1:0] pc_src;
    logic            pc_wr;
    logic            wdata_sel;
  } ctrl_t;

  localparam ctrl_t CTRL_IDLE = '0;

endpackage

// File: rtl/mc_state_reg.sv
module mc_state_reg
  import mc_ctrl_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  state_t nxt,
  output state_t cur
);

  always_ff @(posedge clk) begin
    if (rst) cur <= S_FETCH;
    else     cur <= nxt;
  end

endmodule

// File: rtl/mc_next_state.sv
module mc_next_state
  import mc_ctrl_pkg::*;
#(
  parameter int              OPW     = 6,
  parameter logic [OPW-1:0]  OP_RTYPE = 0,
  parameter logic [OPW-1:0]  OP_LW    = 35,
  parameter logic [OPW-1:0]  OP_SW    = 43,
  parameter logic [OPW-1:0]  OP_BEQ   = 4,
  parameter logic [OPW-1:0]  OP_JMEM  = 60
)(
  input  state_t         cur,
  input  logic [OPW-1:0] opcode,
  output state_t         nxt,
  output logic           op_known
);

  // Dispatch target for an opcode seen in decode; fetch when unsupported.
  function automatic state_t dispatch(input logic [OPW-1:0] op);
    if      (op == OP_RTYPE) return S_REXE;
    else if (op == OP_LW)    return S_LWADR;
    else if (op == OP_SW)    return S_SWADR;
    else if (op == OP_BEQ)   return S_BEQ;
    else if (op == OP_JMEM)  return S_JMADR;
    else                     return S_FETCH;
  endfunction

  state_t target;
  assign target   = dispatch(opcode);
  assign op_known = (target != S_FETCH);

  always_comb begin
    unique case (cur)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: nxt = target;
      S_LWADR:  nxt = S_LWRD;
      S_LWRD:   nxt = S_LWWB;
      S_SWADR:  nxt = S_SWWR;
      S_REXE:   nxt = S_RWB;
      S_JMADR:  nxt = S_JMST;
      default:  nxt = S_FETCH;
    endcase
  end

endmodule

// File: rtl/mc_out_decode.sv
module mc_out_decode
  import mc_ctrl_pkg::*;
(
  input  state_t cur,
  input  logic   zero,
  output ctrl_t  c
);

  always_comb begin
    c = CTRL_IDLE;
    unique case (cur)
      S_FETCH: begin
        c.addr_sel  = AS_PC;
        c.mem_rd    = 1'b1;
        c.ir_wr     = 1'b1;
        c.alu_src_b = SB_FOUR;
        c.alu_op    = ALU_ADD;
        c.pc_src    = PS_ALU;
        c.pc_wr     = 1'b1;
      end
      S_DECODE: begin
        c.alu_src_b = SB_IMMSH;
        c.alu_op    = ALU_ADD;
      end
      S_LWADR, S_SWADR: begin
        c.alu_src_a = 1'b1;
        c.alu_src_b = SB_IMM;
        c.alu_op    = ALU_ADD;
      end
      S_LWRD: begin
        c.addr_sel = AS_ALUOUT;
        c.mem_rd   = 1'b1;
      end
      S_LWWB: begin
        c.mem_to_reg = 1'b1;
        c.reg_wr     = 1'b1;
      end
      S_SWWR: begin
        c.addr_sel  = AS_ALUOUT;
        c.mem_wr    = 1'b1;
        c.wdata_sel = 1'b0;
      end
      S_REXE: begin
        c.alu_src_a = 1'b1;
        c.alu_src_b = SB_REGB;
        c.alu_op    = ALU_FUNC;
      end
      S_RWB: begin
        c.reg_dst = 1'b1;
        c.reg_wr  = 1'b1;
      end
      S_BEQ: begin
        c.alu_src_a = 1'b1;
        c.alu_src_b = SB_REGB;
        c.alu_op    = ALU_SUB;
        c.pc_src    = PS_ALUOUT;
        c.pc_wr     = zero;
      end
      S_JMADR: begin
        c.addr_sel  = AS_REGB;
        c.mem_rd    = 1'b1;
        c.alu_src_a = 1'b1;
        c.alu_src_b = SB_IMM;
        c.alu_op    = ALU_ADD;
      end
      S_JMST: begin
        c.addr_sel  = AS_ALUOUT;
        c.mem_wr    = 1'b1;
        c.wdata_sel = 1'b1;
        c.pc_src    = PS_MDR;
        c.pc_wr     = 1'b1;
      end
      default: c = CTRL_IDLE;
    endcase
  end

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_ctrl_pkg::*;
#(
  parameter int             OPW     = 6,
  parameter logic [OPW-1:0] OP_JMEM = 60
)(
  input  logic            clk,
  input  logic            rst,
  input  logic [OPW-1:0]  opcode,
  input  logic            zero,
  output logic [1:0]      addr_sel,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            ir_wr,
  output logic            reg_dst,
  output logic            mem_to_reg,
  output logic            reg_wr,
  output logic            alu_src_a,
  output logic [1:0]      alu_src_b,
  output logic [1:0]      alu_op,
  output logic [1:0]      pc_src,
  output logic            pc_wr,
  output logic            wdata_sel
);

  state_t cur;
  state_t nxt;
  ctrl_t  c;
  logic   op_known;
  logic   in_decode;

  assign in_decode = (cur == S_DECODE);

  mc_state_reg u_state (
    .clk (clk),
    .rst (rst),
    .nxt (nxt),
    .cur (cur)
  );

  mc_next_state #(
    .OPW     (OPW),
    .OP_JMEM (OP_JMEM)
  ) u_next (
    .cur      (cur),
    .opcode   (opcode),
    .nxt      (nxt),
    .op_known (op_known)
  );

  mc_out_decode u_out (
    .cur  (cur),
    .zero (zero),
    .c    (c)
  );

  assign addr_sel   = c.addr_sel;
  assign mem_rd     = c.mem_rd;
  assign mem_wr     = c.mem_wr;
  assign ir_wr      = c.ir_wr;
  assign reg_dst    = c.reg_dst;
  assign mem_to_reg = c.mem_to_reg;
  assign reg_wr     = c.reg_wr;
  assign alu_src_a  = c.alu_src_a;
  assign alu_src_b  = c.alu_src_b;
  assign alu_op     = c.alu_op;
  assign pc_src     = c.pc_src;
  assign pc_wr      = c.pc_wr;
  assign wdata_sel  = c.wdata_sel;

endmodule

// File: rtl/mc_ctrl_chk.sv
module mc_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       zero,
  input logic [1:0] addr_sel,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       ir_wr,
  input logic       reg_wr,
  input logic [1:0] alu_src_b,
  input logic [1:0] alu_op,
  input logic [1:0] pc_src,
  input logic       pc_wr,
  input logic       wdata_sel,
  input logic       in_decode,
  input logic       op_known
);

  // R3: fetch is always followed by the decode cycle
  p_fetch_then_decode_r3: assert property (@(posedge clk) disable iff (rst)
    ir_wr |=> (!ir_wr && !pc_wr && alu_src_b == 2'd3 && alu_op == 2'd0));

  // R4 and R5: a register writeback is always the last cycle
  p_writeback_ends_r4: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> ir_wr);

  // R6 and R8: a memory write is always the last cycle
  p_write_ends_r6: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> ir_wr);

  // R7: branch completion writes PC only on zero
  p_branch_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (alu_op == 2'd1) |-> (pc_wr == zero && pc_src == 2'd1));

  // R8: read through register B is followed by the store-and-jump cycle
  p_jump_store_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && addr_sel == 2'd2) |=>
      (mem_wr && addr_sel == 2'd1 && wdata_sel && pc_src == 2'd2 && pc_wr));

  // R9: unsupported opcode in decode goes back to fetch
  p_unknown_fetch_r9: assert property (@(posedge clk) disable iff (rst)
    (in_decode && !op_known) |=> ir_wr);

  // R10: memory strobes are exclusive
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd, mem_wr}));

endmodule

bind mc_ctrl mc_ctrl_chk u_chk (.*);

// File: tb/mc_ctrl_tb.sv
`timescale 1ns/1ps
module mc_ctrl_tb;

  localparam int OPW = 6;
  localparam logic [OPW-1:0] OP_R   = 6'd0;
  localparam logic [OPW-1:0] OP_LW  = 6'd35;
  localparam logic [OPW-1:0] OP_SW  = 6'd43;
  localparam logic [OPW-1:0] OP_BEQ = 6'd4;
  localparam logic [OPW-1:0] OP_JM  = 6'd60;
  localparam logic [OPW-1:0] OP_BAD = 6'd2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [OPW-1:0] opcode = '0;
  logic zero = 1'b0;
  logic [1:0] addr_sel, alu_src_b, alu_op, pc_src;
  logic mem_rd, mem_wr, ir_wr, reg_dst, mem_to_reg, reg_wr, alu_src_a, pc_wr, wdata_sel;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  mc_ctrl #(.OPW(OPW), .OP_JMEM(OP_JM)) u_dut (
    .clk(clk), .rst(rst), .opcode(opcode), .zero(zero),
    .addr_sel(addr_sel), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr),
    .reg_dst(reg_dst), .mem_to_reg(mem_to_reg), .reg_wr(reg_wr),
    .alu_src_a(alu_src_a), .alu_src_b(alu_src_b), .alu_op(alu_op),
    .pc_src(pc_src), .pc_wr(pc_wr), .wdata_sel(wdata_sel)
  );

  // Pack: addr_sel, rd, wr, irw, dst, m2r, rw, srca, srcb, aop, psrc, pcw, wdsel
  function automatic logic [16:0] mk(input int as_, mr, mw, irw, rd, m2r, rw,
                                     sa, sb, aop, ps, pw, wd);
    logic [16:0] v;
    v = {as_[1:0], mr[0], mw[0], irw[0], rd[0], m2r[0], rw[0], sa[0],
         sb[1:0], aop[1:0], ps[1:0], pw[0], wd[0]};
    return v;
  endfunction

  function automatic logic [16:0] observed();
    return {addr_sel, mem_rd, mem_wr, ir_wr, reg_dst, mem_to_reg, reg_wr,
            alu_src_a, alu_src_b, alu_op, pc_src, pc_wr, wdata_sel};
  endfunction

  // Expected control word per step, written from the requirements
  function automatic logic [16:0] v_fetch();  return mk(0,1,0,1,0,0,0,0,1,0,0,1,0); endfunction // R2
  function automatic logic [16:0] v_decode(); return mk(0,0,0,0,0,0,0,0,3,0,0,0,0); endfunction // R3
  function automatic logic [16:0] v_adr();    return mk(0,0,0,0,0,0,0,1,2,0,0,0,0); endfunction
  function automatic logic [16:0] v_lwrd();   return mk(1,1,0,0,0,0,0,0,0,0,0,0,0); endfunction
  function automatic logic [16:0] v_lwwb();   return mk(0,0,0,0,0,1,1,0,0,0,0,0,0); endfunction
  function automatic logic [16:0] v_swwr();   return mk(1,0,1,0,0,0,0,0,0,0,0,0,0); endfunction
  function automatic logic [16:0] v_rexe();   return mk(0,0,0,0,0,0,0,1,0,2,0,0,0); endfunction
  function automatic logic [16:0] v_rwb();    return mk(0,0,0,0,1,0,1,0,0,0,0,0,0); endfunction
  function automatic logic [16:0] v_beq(input int z); return mk(0,0,0,0,0,0,0,1,0,1,1,z,0); endfunction
  function automatic logic [16:0] v_jmadr();  return mk(2,1,0,0,0,0,0,1,2,0,0,0,0); endfunction
  function automatic logic [16:0] v_jmst();   return mk(1,0,1,0,0,0,0,0,0,0,2,1,1); endfunction

  task automatic check(input string tag, input logic [16:0] exp);
    logic [16:0] got;
    got = observed();
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s at %0t: got %h expected %h", tag, $time, got, exp);
    end
    // R10: read and write strobes never together
    checks++;
    if (mem_rd && mem_wr) begin
      fails++;
      $display("FAIL R10 at %0t: got rd=%0b wr=%0b expected exclusive", $time, mem_rd, mem_wr);
    end
  endtask

  // Reference model: queue of expected words for one instruction, starting in fetch.
  task automatic run_instr(input logic [OPW-1:0] op, input int z,
                           input logic [OPW-1:0] junk, input string tag);
    logic [16:0] q[$];
    string t[$];
    q.push_back(v_fetch());  t.push_back("R2");
    q.push_back(v_decode()); t.push_back("R3");
    if (op == OP_R) begin
      q.push_back(v_rexe()); q.push_back(v_rwb());
    end else if (op == OP_LW) begin
      q.push_back(v_adr()); q.push_back(v_lwrd()); q.push_back(v_lwwb());
    end else if (op == OP_SW) begin
      q.push_back(v_adr()); q.push_back(v_swwr());
    end else if (op == OP_BEQ) begin
      q.push_back(v_beq(z));
    end else if (op == OP_JM) begin
      q.push_back(v_jmadr()); q.push_back(v_jmst());
    end
    while (t.size() < q.size()) t.push_back(tag);
    for (int i = 0; i < q.size(); i++) begin
      @(negedge clk);
      opcode = (i == 1) ? op : junk;
      if (op == OP_BEQ && i == 2) zero = z[0];
      else                        zero = i[0];  // R11: flag toggles where ignored
      #1;
      check(t[i], q[i]);
    end
  endtask

  initial begin
    #(8 * 5000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset enters fetch
    repeat (2) @(posedge clk);
    @(negedge clk); #1;
    check("R1", v_fetch());
    @(posedge clk); #1 rst = 1'b0;

    run_instr(OP_R,   0, OP_R,   "R4");
    run_instr(OP_LW,  0, OP_R,   "R5");
    run_instr(OP_SW,  0, OP_R,   "R6");
    run_instr(OP_BEQ, 1, OP_R,   "R7");
    run_instr(OP_BEQ, 0, OP_R,   "R7");
    run_instr(OP_JM,  0, OP_R,   "R8");
    run_instr(OP_BAD, 0, OP_R,   "R9");
    run_instr(OP_BAD, 0, OP_JM,  "R9");
    // R11: valid opcodes outside decode must not alter the path
    run_instr(OP_LW,  0, OP_SW,  "R11");
    run_instr(OP_SW,  0, OP_JM,  "R11");
    run_instr(OP_R,   0, OP_BEQ, "R11");
    run_instr(OP_JM,  0, OP_LW,  "R11");
    run_instr(OP_BEQ, 1, OP_JM,  "R11");

    // R1: reset in the middle of a load
    @(negedge clk); opcode = OP_R;  #1; check("R1", v_fetch());
    @(negedge clk); opcode = OP_LW; #1; check("R1", v_decode());
    @(negedge clk); opcode = OP_R;  #1; check("R1", v_adr());
    rst = 1'b1;
    @(negedge clk); #1; check("R1", v_fetch());
    @(posedge clk); #1 rst = 1'b0;
    run_instr(OP_JM, 0, OP_R, "R8");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule